// File: doc/BRIEF.md
# Six-Lane Serial Receive Multiplexer with Longitudinal Parity Mark

The block takes serial bit streams from up to six synchronous receivers. Each lane has a data bit and a qualifying enable. A lane shifts in enabled bits, most significant bit first, until it has 24 of them. It then treats the word as part of a record. A record is eight data words followed by one check word. The check word is the bitwise XOR of the eight data words. The lane keeps a running XOR and compares it against the check word when that word arrives.

Finished data words go to a shared output stage. The stage serves the lanes in a fixed rotating order and presents one word at a time on a request/grant memory write port. The address carries the lane number and the position of the word inside the record. The check word itself is never written. When the check fails, the data is still written. The failure travels as a 25th bit on the eighth data word of that record. One cycle after each accepted write, a done pulse tells the host that the transfer has reached memory. Records follow each other without a break for as long as the receivers send.

Top module: `multisrc_rx_mux`

## Requirements
- R1: While reset is held and after its release with no input, mem_req and mem_done are 0.
- R2: A lane builds a word from the bits present on the cycles where its rx_en is 1, first bit in bit 23. Bits on cycles with rx_en at 0 have no effect on the word written.
- R3: Each of the eight data words of a record is written exactly once, at mem_addr = {lane number in bits [5:3], word position 0..7 in bits [2:0]}. The ninth (check) word is never written.
- R4: mem_wdata[24] is 1 only on the position-7 word, and only when the XOR of the eight data words differs from the check word. Otherwise it is 0.
- R5: A record whose check fails still has all eight data words written unchanged in bits [23:0].
- R6: While mem_req is 1 and mem_gnt is 0, mem_req stays 1 on the next cycle and mem_addr and mem_wdata do not change.
- R7: mem_done is 1 in exactly the cycle after each cycle in which mem_req and mem_gnt were both 1, and 0 otherwise.
- R8: When several lanes hold words, they are served in rotating order, starting from the lane after the last one served. After reset, lane 0 comes first.
- R9: After a check word, the next word of a lane starts a new record at position 0 with a cleared running XOR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 6 | Serial data bit, one per lane |
| rx_en | input | 6 | Bit qualifier, one per lane |
| mem_gnt | input | 1 | Memory accepts the presented write |
| mem_req | output | 1 | Write request |
| mem_addr | output | 6 | {lane, word position} |
| mem_wdata | output | 25 | {parity mark, 24-bit data word} |
| mem_done | output | 1 | One-cycle pulse after each accepted write |

## Verification
The hardest case to reach is the rotation order. It only shows when every lane holds a finished word at the same moment while the port is stalled. Random traffic rarely lines the lanes up that way. The bench therefore starts with a directed phase: all six lanes receive bits on every cycle from the same cycle on, and the grant is held low until every lane is waiting. The bench then checks the order of the writes that follow. Longer random phases follow, with gaps in the bit enables, junk data under low enables, random grant stalls and records with deliberately corrupted check words. They check the parity mark, the addresses, the held values during stalls and the done pulse on every cycle.

// File: rtl/rxmux_pkg.sv
package rxmux_pkg;
  localparam int DEF_NUM_SRC   = 6;
  localparam int DEF_WORD_W    = 24;
  localparam int DEF_REC_WORDS = 8;

  // next lane index in the rotating service order
  function automatic int rr_step(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/rxmux_lane.sv
module rxmux_lane #(
  parameter int WORD_W    = rxmux_pkg::DEF_WORD_W,
  parameter int REC_WORDS = rxmux_pkg::DEF_REC_WORDS,
  localparam int IDX_W    = $clog2(REC_WORDS),
  localparam int CNT_W    = $clog2(REC_WORDS + 1),
  localparam int BIT_W    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_en,
  input  logic              take,
  output logic              pend_v,
  output logic [WORD_W-1:0] pend_data,
  output logic              pend_mark,
  output logic [IDX_W-1:0]  pend_idx
);
  logic [WORD_W-2:0] shreg;
  logic [BIT_W-1:0]  bit_cnt;
  logic [CNT_W-1:0]  word_idx;
  logic [WORD_W-1:0] lrc_acc;
  logic [WORD_W-1:0] hold_word;

  // named internal events
  logic [WORD_W-1:0] assembled;
  logic              word_done;
  logic              is_check;
  logic              is_last;
  logic              load_pend;

  function automatic logic lrc_fails(input logic [WORD_W-1:0] acc,
                                     input logic [WORD_W-1:0] chk);
    return |(acc ^ chk);
  endfunction

  assign assembled = {shreg, bit_in};
  assign word_done = bit_en && (bit_cnt == BIT_W'(WORD_W - 1));
  assign is_check  = (word_idx == CNT_W'(REC_WORDS));
  assign is_last   = (word_idx == CNT_W'(REC_WORDS - 1));
  assign load_pend = word_done && !is_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      bit_cnt  <= '0;
    end else if (bit_en) begin
      shreg    <= assembled[WORD_W-2:0];
      bit_cnt  <= word_done ? '0 : bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_idx  <= '0;
      lrc_acc   <= '0;
      hold_word <= '0;
    end else if (word_done) begin
      if (is_check) begin
        word_idx <= '0;
        lrc_acc  <= '0;
      end else begin
        word_idx <= word_idx + 1'b1;
        lrc_acc  <= lrc_acc ^ assembled;
        if (is_last) hold_word <= assembled;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_data <= '0;
      pend_mark <= 1'b0;
      pend_idx  <= '0;
    end else if (load_pend) begin
      pend_v    <= 1'b1;
      pend_data <= is_check ? hold_word : assembled;
      pend_mark <= is_check ? lrc_fails(lrc_acc, assembled) : 1'b0;
      pend_idx  <= is_check ? IDX_W'(REC_WORDS - 1) : word_idx[IDX_W-1:0];
    end else if (take) begin
      pend_v    <= 1'b0;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && !take) |-> !load_pend)
    else $error("lane word completed while holding slot occupied");

  assert_take_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend_v)
    else $error("lane drained while empty");

  assert_mark_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && pend_mark) |-> (pend_idx == IDX_W'(REC_WORDS - 1)))
    else $error("parity mark on a word other than the last");
endmodule

// File: rtl/rxmux_rr.sv
module rxmux_rr #(
  parameter int N     = rxmux_pkg::DEF_NUM_SRC,
  parameter int SRC_W = $clog2(N)
) (
  input  logic [N-1:0]     ready,
  input  logic [SRC_W-1:0] last,
  output logic             any,
  output logic [SRC_W-1:0] pick
);
  always_comb begin
    int c;
    any  = 1'b0;
    pick = '0;
    c    = int'(last);
    for (int k = 0; k < N; k++) begin
      c = rxmux_pkg::rr_step(c, N);
      if (!any && ready[c]) begin
        any  = 1'b1;
        pick = SRC_W'(c);
      end
    end
  end
endmodule

// File: rtl/multisrc_rx_mux.sv
module multisrc_rx_mux #(
  parameter int NUM_SRC   = rxmux_pkg::DEF_NUM_SRC,
  parameter int WORD_W    = rxmux_pkg::DEF_WORD_W,
  parameter int REC_WORDS = rxmux_pkg::DEF_REC_WORDS,
  localparam int SRC_W    = $clog2(NUM_SRC),
  localparam int IDX_W    = $clog2(REC_WORDS),
  localparam int ADDR_W   = SRC_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] rx_bit,
  input  logic [NUM_SRC-1:0] rx_en,
  input  logic               mem_gnt,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [WORD_W:0]    mem_wdata,
  output logic               mem_done
);
  logic [NUM_SRC-1:0] ln_v;
  logic [NUM_SRC-1:0] ln_mark;
  logic [NUM_SRC-1:0] take_vec;
  logic [WORD_W-1:0]  ln_data [NUM_SRC];
  logic [IDX_W-1:0]   ln_idx  [NUM_SRC];

  logic               any;
  logic [SRC_W-1:0]   pick;
  logic [SRC_W-1:0]   last_q;
  logic               req_q;
  logic               done_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [WORD_W:0]    data_q;

  // named events
  logic               advance;
  logic               load;
  logic               accept;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    rxmux_lane #(.WORD_W(WORD_W), .REC_WORDS(REC_WORDS)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_in   (rx_bit[i]),
      .bit_en   (rx_en[i]),
      .take     (take_vec[i]),
      .pend_v   (ln_v[i]),
      .pend_data(ln_data[i]),
      .pend_mark(ln_mark[i]),
      .pend_idx (ln_idx[i])
    );
    assign take_vec[i] = load && (pick == SRC_W'(i));
  end

  rxmux_rr #(.N(NUM_SRC), .SRC_W(SRC_W)) u_rr (
    .ready(ln_v),
    .last (last_q),
    .any  (any),
    .pick (pick)
  );

  assign accept  = req_q && mem_gnt;
  assign advance = !req_q || mem_gnt;
  assign load    = advance && any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      last_q <= SRC_W'(NUM_SRC - 1);
      done_q <= 1'b0;
    end else begin
      done_q <= accept;
      if (load) begin
        req_q  <= 1'b1;
        addr_q <= {pick, ln_idx[pick]};
        data_q <= {ln_mark[pick], ln_data[pick]};
        last_q <= pick;
      end else if (mem_gnt) begin
        req_q  <= 1'b0;
      end
    end
  end

  assign mem_req   = req_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign mem_done  = done_q;

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)))
    else $error("write request changed while stalled");

  assert_one_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_vec))
    else $error("more than one lane drained in a cycle");

  assert_load_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|take_vec) |-> advance)
    else $error("lane drained while output stage blocked");
endmodule

// File: tb/multisrc_rx_mux_test.sv
module multisrc_rx_mux_test;
  localparam int NS = 6;
  localparam int WW = 24;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] rx_bit = '0;
  logic [NS-1:0] rx_en = '0;
  logic          mem_gnt = 1'b0;
  logic          mem_req;
  logic [5:0]    mem_addr;
  logic [WW:0]   mem_wdata;
  logic          mem_done;

  always #2 clk = ~clk;

  multisrc_rx_mux uut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_en(rx_en),
    .mem_gnt(mem_gnt), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_done(mem_done)
  );

  int checks = 0;
  int errors = 0;
  bit          bq [NS][$];
  logic [27:0] eq [NS][$];   // {position, mark, word}
  int          order_q[$];
  bit run = 0;
  int en_pct = 100;
  int gnt_mode = 1;          // 0 random, 1 low, 2 high
  int gnt_pct = 60;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // column-wise parity: for each bit position, odd count of ones across words
  function automatic logic [WW-1:0] col_parity(input logic [WW-1:0] w [RW]);
    logic [WW-1:0] r;
    for (int b = 0; b < WW; b++) begin
      int ones = 0;
      for (int i = 0; i < RW; i++) ones += int'(w[i][b]);
      r[b] = ones[0];
    end
    return r;
  endfunction

  task automatic push_record(input int s, input logic [WW-1:0] w [RW], input bit bad);
    logic [WW-1:0] chk;
    chk = col_parity(w);
    if (bad) chk[$urandom_range(WW-1)] ^= 1'b1;
    for (int i = 0; i <= RW; i++) begin
      logic [WW-1:0] x;
      x = (i == RW) ? chk : w[i];
      for (int b = WW-1; b >= 0; b--) bq[s].push_back(x[b]);
    end
    for (int i = 0; i < RW; i++)
      eq[s].push_back({3'(i), (bad && i == RW-1), w[i]});
  endtask

  // driver and monitor, one pass per falling edge
  initial begin
    bit prev_acc = 0;
    bit prev_wait = 0;
    logic [5:0]  p_addr = '0;
    logic [WW:0] p_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        check(mem_done == prev_acc, "R7 done pulse", 32'(mem_done), 32'(prev_acc));
        if (prev_wait)
          check(mem_req && mem_addr == p_addr && mem_wdata == p_data, "R6 hold",
                {mem_req, mem_addr, mem_wdata}, {1'b1, p_addr, p_data});
      end
      for (int s = 0; s < NS; s++) begin
        if (run && bq[s].size() > 0 && $urandom_range(99) < en_pct) begin
          rx_en[s]  = 1'b1;
          rx_bit[s] = bq[s].pop_front();
        end else begin
          rx_en[s]  = 1'b0;
          rx_bit[s] = 1'($urandom);
        end
      end
      case (gnt_mode)
        0: mem_gnt = ($urandom_range(99) < gnt_pct);
        1: mem_gnt = 1'b0;
        default: mem_gnt = 1'b1;
      endcase
      prev_acc  = rst_n && mem_req && mem_gnt;
      prev_wait = rst_n && mem_req && !mem_gnt;
      p_addr = mem_addr;
      p_data = mem_wdata;
      if (prev_acc) begin
        int s;
        s = int'(mem_addr[5:3]);
        order_q.push_back(s);
        if (s >= NS || eq[s].size() == 0) begin
          check(0, "R3 unexpected write", 32'(mem_addr), 32'h0);
        end else begin
          logic [27:0] e;
          e = eq[s].pop_front();
          check(mem_addr[2:0] == e[27:25], "R3 position", 32'(mem_addr[2:0]), 32'(e[27:25]));
          check(mem_wdata[WW] == e[24], "R4 parity mark", 32'(mem_wdata[WW]), 32'(e[24]));
          check(mem_wdata[WW-1:0] == e[WW-1:0], "R2 R5 data word",
                32'(mem_wdata[WW-1:0]), 32'(e[WW-1:0]));
        end
      end
    end
  end

  function automatic bit all_drained();
    for (int s = 0; s < NS; s++)
      if (bq[s].size() != 0 || eq[s].size() != 0) return 0;
    return 1;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [WW-1:0] w [RW];
    void'($urandom(32'h5eed_0042));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(mem_req == 0 && mem_done == 0, "R1 in reset", {mem_req, mem_done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(mem_req == 0 && mem_done == 0, "R1 after reset", {mem_req, mem_done}, 0);

    // directed: all lanes aligned, grant held low, then rotation order (R8)
    for (int s = 0; s < NS; s++) begin
      for (int i = 0; i < RW; i++) w[i] = WW'($urandom);
      if (s == 3) for (int i = 0; i < RW; i++) w[i] = '0;   // all-zero good record
      push_record(s, w, s == 2);                             // lane 2 bad (R5)
    end
    en_pct = 100;
    gnt_mode = 1;
    run = 1;
    repeat (30) @(negedge clk);
    gnt_mode = 2;
    repeat (12) @(negedge clk);
    for (int k = 0; k < NS; k++)
      check(order_q.size() > k && order_q[k] == k, "R8 rotation order",
            order_q.size() > k ? 32'(order_q[k]) : 32'hffff, 32'(k));
    while (!all_drained()) @(negedge clk);

    // back-to-back records with bit gaps and random stalls (R9)
    gnt_mode = 0;
    for (int phase = 0; phase < 3; phase++) begin
      en_pct  = (phase == 1) ? 100 : 70;
      gnt_pct = (phase == 2) ? 40 : 65;
      for (int r = 0; r < 4; r++)
        for (int s = 0; s < NS; s++) begin
          for (int i = 0; i < RW; i++) w[i] = WW'($urandom);
          push_record(s, w, $urandom_range(99) < 30);
        end
      while (!all_drained()) @(negedge clk);
    end

    run = 0;
    repeat (40) @(negedge clk);
    for (int s = 0; s < NS; s++)
      check(eq[s].size() == 0, "R3 R9 all words written", 32'(eq[s].size()), 0);
    check(mem_req == 0, "R3 no check word written", 32'(mem_req), 0);
    finish_run();
  end
endmodule